// File: doc/BRIEF.md
# Segment Selector Load Checker

This block judges whether a 16-bit selector may be written into a data or stack segment register while the processor runs in protected mode. The caller presents a selector, a flag that says whether the target is the stack segment or one of the four data segments, the current privilege level, the two descriptor table limits, and the access-rights byte that an earlier descriptor fetch returned. One clock later the block answers. The answer is either permission to load, with or without a valid descriptor, or a single fault with its class and error code.

The rules differ by target. A null selector is rejected for the stack but accepted for a data segment, where it leaves the descriptor marked invalid. The stack needs an exact privilege match and a writable data segment. A data segment accepts data or readable code under a less-or-equal privilege rule, and conforming code skips that rule. A segment that is not present raises a stack fault for the stack and a not-present fault for the others. When several rules fail, a fixed priority picks the one fault that is reported.

Top module: `seg_load_checker`

## Requirements
- R1: Reset clears every output. A request sampled with `req_valid` high gives `rsp_valid` high on the next clock edge with the verdict. When `rsp_valid` is low, `load_en`, `desc_valid`, `fault`, `fault_kind` and `fault_code` are all zero.
- R2: A selector whose bits 15:2 are all zero is null. Loading a null selector into the stack segment (`to_stack`=1) gives `fault`=1, `fault_kind`=2'b01 (general protection) and `fault_code`=0.
- R3: Loading a null selector into a data segment gives `load_en`=1, `desc_valid`=0 and `fault`=0.
- R4: For a non-null selector, the table limit is `ldt_limit` when selector bit 2 is 1 and `gdt_limit` when it is 0. If {selector[15:3], 3'b111} is greater than that limit, the result is general protection with `fault_code` equal to the selector. A value equal to the limit passes.
- R5: Access-rights layout: bit 7 present, bits 6:5 DPL, bit 4 S (1 = code or data). Type bit 3 is 1 for code. For data, bit 1 is writable. For code, bit 2 is conforming and bit 1 is readable. The stack accepts only S=1 writable data with selector RPL (bits 1:0) equal to CPL and DPL equal to CPL. Anything else is general protection with the selector as the code.
- R6: A stack load that passes R4 and R5 but has present=0 gives `fault_kind`=2'b10 (stack fault) with the selector as the code.
- R7: A data load accepts only S=1 with either data, or code with the readable bit set. Anything else is general protection with the selector as the code.
- R8: For a data load of a data segment or of non-conforming code, both RPL and CPL must be less than or equal to DPL, or the result is general protection with the selector as the code. Conforming readable code is exempt.
- R9: A data load that passes R4, R7 and R8 but has present=0 gives `fault_kind`=2'b11 (not present) with the selector as the code.
- R10: A non-null load that passes every check gives `load_en`=1, `desc_valid`=1, `fault`=0 and `fault_kind`=2'b00.
- R11: Checks run in the order null, limit, type, privilege, present. Only the first failing check is reported, and `load_en` and `fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| sel | input | 16 | Selector to be loaded |
| to_stack | input | 1 | 1 = stack segment, 0 = data segment |
| cpl | input | 2 | Current privilege level |
| gdt_limit | input | LIM_W | Global table limit in bytes |
| ldt_limit | input | LIM_W | Local table limit in bytes |
| ar_byte | input | 8 | Access-rights byte of the fetched descriptor |
| rsp_valid | output | 1 | Verdict valid |
| load_en | output | 1 | Register may be loaded |
| desc_valid | output | 1 | Loaded descriptor is usable |
| fault | output | 1 | A fault is raised |
| fault_kind | output | 2 | 00 none, 01 general protection, 10 stack, 11 not present |
| fault_code | output | 16 | Error code pushed with the fault |

## Verification
The hardest outcome to reach is a present-bit fault, stack or not-present. It only appears when the selector sits inside its table, the type is right and every privilege comparison holds, so random bytes almost never get there. The stimulus builds these cases on purpose: it picks RPL, CPL and DPL together, clears only the present bit, and puts the index exactly on the limit and one step past it. Random requests with a biased access-rights byte then cover the priority between failing checks.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;
  typedef enum logic [1:0] {
    FK_NONE = 2'b00,
    FK_GP   = 2'b01,
    FK_STK  = 2'b10,
    FK_NP   = 2'b11
  } fault_kind_e;

  typedef struct packed {
    logic       present;
    logic [1:0] dpl;
    logic       non_sys;
    logic       is_code;
    logic       conforming;
    logic       readable;
    logic       writable;
  } ar_fields_t;

  typedef struct packed {
    logic        load;
    logic        dvalid;
    logic        fault;
    fault_kind_e kind;
    logic [15:0] code;
  } verdict_t;
endpackage

// File: rtl/seg_ar_decode.sv
module seg_ar_decode
  import seg_load_pkg::*;
(
  input  logic [7:0] ar_byte,
  output ar_fields_t fields
);
  always_comb begin
    fields.present    = ar_byte[7];
    fields.dpl        = ar_byte[6:5];
    fields.non_sys    = ar_byte[4];
    fields.is_code    = ar_byte[3];
    fields.conforming = ar_byte[3] & ar_byte[2];
    fields.readable   = ar_byte[3] & ar_byte[1];
    fields.writable   = ~ar_byte[3] & ar_byte[1];
  end
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check #(
  parameter int LIM_W = 16
) (
  input  logic [15:0]      sel,
  input  logic [LIM_W-1:0] gdt_limit,
  input  logic [LIM_W-1:0] ldt_limit,
  output logic             in_limit
);
  localparam int CW = (LIM_W > 16) ? LIM_W : 16;

  logic [CW-1:0] last_byte;
  logic [CW-1:0] table_lim;

  always_comb begin
    last_byte = CW'({sel[15:3], 3'b111});
    table_lim = sel[2] ? CW'(ldt_limit) : CW'(gdt_limit);
    in_limit  = (last_byte <= table_lim);
  end
endmodule

// File: rtl/seg_rules.sv
module seg_rules
  import seg_load_pkg::*;
(
  input  logic [15:0] sel,
  input  logic        to_stack,
  input  logic [1:0]  cpl,
  input  ar_fields_t  f,
  input  logic        in_limit,
  output verdict_t    v
);
  logic       is_null;
  logic [1:0] rpl;
  logic       type_ok;
  logic       priv_ok;

  always_comb begin
    is_null = (sel[15:2] == 14'd0);
    rpl     = sel[1:0];
    if (to_stack) begin
      type_ok = f.non_sys & f.writable;
      priv_ok = (rpl == cpl) && (f.dpl == cpl);
    end else begin
      type_ok = f.non_sys & (~f.is_code | f.readable);
      priv_ok = f.conforming || ((rpl <= f.dpl) && (cpl <= f.dpl));
    end
  end

  always_comb begin
    v = '{load: 1'b0, dvalid: 1'b0, fault: 1'b1, kind: FK_GP, code: sel};
    if (is_null) begin
      if (to_stack) v.code = 16'd0;
      else v = '{load: 1'b1, dvalid: 1'b0, fault: 1'b0, kind: FK_NONE, code: 16'd0};
    end else if (!in_limit || !type_ok || !priv_ok) begin
      v.kind = FK_GP;
    end else if (!f.present) begin
      v.kind = to_stack ? FK_STK : FK_NP;
    end else begin
      v = '{load: 1'b1, dvalid: 1'b1, fault: 1'b0, kind: FK_NONE, code: 16'd0};
    end
  end
endmodule

// File: rtl/seg_load_checker.sv
module seg_load_checker
  import seg_load_pkg::*;
#(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [15:0]      sel,
  input  logic             to_stack,
  input  logic [1:0]       cpl,
  input  logic [LIM_W-1:0] gdt_limit,
  input  logic [LIM_W-1:0] ldt_limit,
  input  logic [7:0]       ar_byte,
  output logic             rsp_valid,
  output logic             load_en,
  output logic             desc_valid,
  output logic             fault,
  output logic [1:0]       fault_kind,
  output logic [15:0]      fault_code
);
  ar_fields_t fields;
  logic       in_limit;
  verdict_t   verdict;

  seg_ar_decode u_dec (.ar_byte(ar_byte), .fields(fields));

  seg_limit_check #(.LIM_W(LIM_W)) u_lim (
    .sel(sel), .gdt_limit(gdt_limit), .ldt_limit(ldt_limit), .in_limit(in_limit)
  );

  seg_rules u_rules (
    .sel(sel), .to_stack(to_stack), .cpl(cpl), .f(fields),
    .in_limit(in_limit), .v(verdict)
  );

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid  <= 1'b0;
      load_en    <= 1'b0;
      desc_valid <= 1'b0;
      fault      <= 1'b0;
      fault_kind <= 2'b00;
      fault_code <= 16'd0;
    end else begin
      rsp_valid  <= 1'b1;
      load_en    <= verdict.load;
      desc_valid <= verdict.dvalid;
      fault      <= verdict.fault;
      fault_kind <= verdict.kind;
      fault_code <= verdict.code;
    end
  end

  // R1: one-cycle response
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!load_en && !fault && fault_code == 16'd0));
  // R2: null stack selector
  a_r2_null_stack: assert property (@(posedge clk) disable iff (rst)
    (req_valid && to_stack && sel[15:2] == 14'd0)
      |=> (fault && fault_kind == 2'b01 && fault_code == 16'd0));
  // R3: null data selector
  a_r3_null_data: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !to_stack && sel[15:2] == 14'd0)
      |=> (load_en && !desc_valid && !fault));
  // R6 / R9: fault class tied to target
  a_r6_stack_kind: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !to_stack) |=> (fault_kind != 2'b10));
  a_r9_np_kind: assert property (@(posedge clk) disable iff (rst)
    (req_valid && to_stack) |=> (fault_kind != 2'b11));
  // R11: exclusive verdict
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(load_en && fault));
  a_r10_dvalid_needs_load: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> load_en);
endmodule

// File: tb/sim_seg_load_checker.sv
module sim_seg_load_checker;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [15:0] sel;
  logic        to_stack;
  logic [1:0]  cpl;
  logic [15:0] gdt_limit, ldt_limit;
  logic [7:0]  ar_byte;
  logic        rsp_valid, load_en, desc_valid, fault;
  logic [1:0]  fault_kind;
  logic [15:0] fault_code;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  seg_load_checker #(.LIM_W(16)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .sel(sel), .to_stack(to_stack),
    .cpl(cpl), .gdt_limit(gdt_limit), .ldt_limit(ldt_limit), .ar_byte(ar_byte),
    .rsp_valid(rsp_valid), .load_en(load_en), .desc_valid(desc_valid),
    .fault(fault), .fault_kind(fault_kind), .fault_code(fault_code)
  );

  // expected {load, dvalid, fault, kind[1:0], code[15:0]}
  function automatic logic [20:0] model(input logic [15:0] s, input logic stk,
      input logic [1:0] c, input logic [15:0] gl, input logic [15:0] ll, input logic [7:0] a);
    logic [15:0] lim = s[2] ? ll : gl;
    logic [1:0] rpl = s[1:0];
    logic [1:0] dpl = a[6:5];
    logic code_seg = a[3];
    logic ty, pr;
    if (s[15:2] == 0)
      return stk ? {3'b001, 2'b01, 16'd0} : {3'b100, 2'b00, 16'd0};
    if ({s[15:3], 3'b111} > lim) return {3'b001, 2'b01, s};
    if (stk) begin
      ty = a[4] && !code_seg && a[1];
      pr = (rpl == c) && (dpl == c);
    end else begin
      ty = a[4] && (!code_seg || a[1]);
      pr = (code_seg && a[2]) || (rpl <= dpl && c <= dpl);
    end
    if (!ty || !pr) return {3'b001, 2'b01, s};
    if (!a[7]) return {3'b001, stk ? 2'b10 : 2'b11, s};
    return {3'b110, 2'b00, 16'd0};
  endfunction

  task automatic check(input string tag, input logic [20:0] act, input logic [20:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic req(input string tag, input logic [15:0] s, input logic stk,
      input logic [1:0] c, input logic [15:0] gl, input logic [15:0] ll, input logic [7:0] a);
    @(negedge clk);
    sel = s; to_stack = stk; cpl = c; gdt_limit = gl; ldt_limit = ll; ar_byte = a;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1", {31'd0, rsp_valid}, 32'd1);
    check(tag, {load_en, desc_valid, fault, fault_kind, fault_code}, model(s, stk, c, gl, ll, a));
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; req_valid = 1'b0; sel = '0; to_stack = 1'b0; cpl = '0;
    gdt_limit = '0; ldt_limit = '0; ar_byte = '0;
    repeat (3) @(negedge clk);
    check("R1", {rsp_valid, load_en, desc_valid, fault, fault_kind, fault_code}, 22'd0);
    rst = 1'b0;

    req("R2", 16'h0003, 1'b1, 2'd3, 16'hFFFF, 16'hFFFF, 8'hF2);
    req("R2", 16'h0000, 1'b1, 2'd0, 16'hFFFF, 16'hFFFF, 8'h92);
    req("R3", 16'h0002, 1'b0, 2'd1, 16'h0000, 16'h0000, 8'h00);
    // limit boundary: index 4 -> last byte 0x27
    req("R4", 16'h0020, 1'b0, 2'd0, 16'h0027, 16'h0000, 8'h92);
    req("R4", 16'h0020, 1'b0, 2'd0, 16'h0026, 16'hFFFF, 8'h92);
    req("R4", 16'h0024, 1'b0, 2'd0, 16'hFFFF, 16'h0026, 8'h92);
    req("R4", 16'h0024, 1'b0, 2'd0, 16'h0000, 16'h0027, 8'h92);
    req("R5", 16'h0012, 1'b1, 2'd2, 16'h00FF, 16'h0, 8'hD2);
    req("R5", 16'h0013, 1'b1, 2'd2, 16'h00FF, 16'h0, 8'hD2);
    req("R5", 16'h0012, 1'b1, 2'd2, 16'h00FF, 16'h0, 8'hF2);
    req("R5", 16'h0012, 1'b1, 2'd2, 16'h00FF, 16'h0, 8'hDA);
    req("R6", 16'h0011, 1'b1, 2'd1, 16'h00FF, 16'h0, 8'h32);
    req("R7", 16'h0010, 1'b0, 2'd0, 16'h00FF, 16'h0, 8'h98);
    req("R7", 16'h0010, 1'b0, 2'd0, 16'h00FF, 16'h0, 8'h82);
    req("R8", 16'h0013, 1'b0, 2'd0, 16'h00FF, 16'h0, 8'hC2);
    req("R8", 16'h0010, 1'b0, 2'd3, 16'h00FF, 16'h0, 8'hDA);
    req("R8", 16'h0013, 1'b0, 2'd3, 16'h00FF, 16'h0, 8'h9E);
    req("R9", 16'h0012, 1'b0, 2'd1, 16'h00FF, 16'h0, 8'h52);
    req("R10", 16'h0010, 1'b0, 2'd0, 16'h00FF, 16'h0, 8'h90);
    req("R10", 16'h0013, 1'b1, 2'd3, 16'h00FF, 16'h0, 8'hF2);
    // priority: limit fail beats non-present, bad type
    req("R11", 16'h0808, 1'b1, 2'd0, 16'h0000, 16'h0000, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] s;
      logic [7:0] a;
      s = {3'b000, 10'($urandom_range(0, 40)), 1'($urandom), 2'($urandom)};
      a = 8'($urandom);
      if ($urandom_range(0, 3) != 0) a[7] = 1'b1;
      if ($urandom_range(0, 3) != 0) a[4] = 1'b1;
      req("R11", s, 1'($urandom), 2'($urandom), 16'($urandom_range(0, 400)),
          16'($urandom_range(0, 400)), a);
    end

    @(negedge clk);
    check("R1", {rsp_valid, load_en, fault}, 3'b000);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule